// File: doc/BRIEF.md
# Parking Gate Direction-Sensing Controller

This block watches two light-beam sensors mounted one after the other across a single-lane parking gate. The outer sensor is `sb_i` and the inner sensor is `sf_i`. Each input reads 1 while a car blocks its beam. The block works out the direction of travel from the order in which the two beams are blocked and cleared. When a car has fully passed, it raises a one-cycle `enter_o` or `exit_o` pulse. It also keeps a bounded occupancy count and raises `full_o` when the lot reaches its capacity.

A sequence recogniser with seven states tracks each pass. The states are:

- `ST_IDLE` (0): no car at the gate.
- `ST_IN_OUTER` (1), `ST_IN_BOTH` (2) and `ST_IN_INNER` (3): an inbound car that has blocked the outer beam, both beams, and only the inner beam.
- `ST_OUT_INNER` (4), `ST_OUT_BOTH` (5) and `ST_OUT_OUTER` (6): the same three steps for an outbound car.

The named transitions are:

- **start**: idle moves to the first progress state of either direction.
- **advance**: moves to the next progress state.
- **hold**: the pattern of the current state keeps the state.
- **back**: the previous pattern of the sequence moves one state back.
- **abort**: 00 from a first progress state returns to idle.
- **complete**: 00 from the last progress state returns to idle and raises a pulse.
- **reject**: any other pattern returns to idle with no pulse.

The counter adds one on each entry pulse and removes one on each exit pulse. It never goes past the capacity and never goes below zero.

Top module: `gate_direction_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `enter_o` = 0, `exit_o` = 0, `count_o` = 0 and `full_o` = 0, and the recogniser is idle.
- R2: The pattern {sb_i,sf_i} = 00, 10, 11, 01, 00, with each pattern sampled on a rising clock edge, raises `enter_o` for exactly one cycle. The pulse begins just after the edge that samples the final 00, provided the lot was not full at that edge.
- R3: The pattern 00, 01, 11, 10, 00 raises `exit_o` for exactly one cycle. The pulse begins just after the edge that samples the final 00.
- R4: In a progress state, repeating that state's pattern holds the state. Presenting the previous pattern of the sequence moves back one state. A pass that backs up and then moves forward again still completes with exactly one pulse.
- R5: Returning to 00 from the first progress state of either direction (pattern 10 inbound, 01 outbound) goes to idle with no pulse.
- R6: Any pattern that is not a hold, advance, back, abort or complete for the current state goes to idle with no pulse. In idle, the patterns 00 and 11 keep the block idle.
- R7: `count_o` increases by one on the edge after an `enter_o` pulse and decreases by one on the edge after an `exit_o` pulse.
- R8: `full_o` = 1 exactly when `count_o` equals the capacity CAP (default 64). An entry that completes while `full_o` is 1 gives no `enter_o` pulse and leaves the count unchanged.
- R9: An exit that completes at a count of 0 still pulses `exit_o`, and `count_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| sb_i | input | 1 | Outer beam sensor, 1 = blocked |
| sf_i | input | 1 | Inner beam sensor, 1 = blocked |
| enter_o | output | 1 | One-cycle pulse for a counted entry |
| exit_o | output | 1 | One-cycle pulse for a completed exit |
| count_o | output | 7 | Occupancy count, 0 to CAP |
| full_o | output | 1 | High while the count equals CAP |

## Verification
Clean inbound and outbound passes, run back to back, show that the direction is taken from the order in which the beams are blocked. Passes that hold, reverse by one step and then go forward again separate backing up from aborting. Early returns to 00 and jumps such as 00 to 11 show that incomplete or illegal sequences give no pulse. Filling the lot to capacity and then attempting a 65th entry, together with an exit from an empty lot, exercises both limits of the counter. A random walk mixes clean passes with corrupted patterns, and every cycle is compared against a reference model in the bench.

// File: rtl/gate_pkg.sv
package gate_pkg;
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_IN_OUTER  = 3'd1,
        ST_IN_BOTH   = 3'd2,
        ST_IN_INNER  = 3'd3,
        ST_OUT_INNER = 3'd4,
        ST_OUT_BOTH  = 3'd5,
        ST_OUT_OUTER = 3'd6
    } gate_state_t;

    localparam logic [1:0] PAT_CLEAR = 2'b00;
    localparam logic [1:0] PAT_INNER = 2'b01;
    localparam logic [1:0] PAT_OUTER = 2'b10;
    localparam logic [1:0] PAT_BOTH  = 2'b11;
endpackage

// File: rtl/gate_seq_fsm.sv
module gate_seq_fsm
    import gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] pattern_i,
    input  logic       full_i,
    output logic       enter_o,
    output logic       exit_o
);
    gate_state_t state_q, state_d;
    logic entry_done, exit_done;

    always_comb begin
        state_d    = ST_IDLE;
        entry_done = 1'b0;
        exit_done  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (pattern_i == PAT_OUTER)      state_d = ST_IN_OUTER;
                else if (pattern_i == PAT_INNER) state_d = ST_OUT_INNER;
                else                             state_d = ST_IDLE;
            end
            ST_IN_OUTER: begin
                if (pattern_i == PAT_OUTER)      state_d = ST_IN_OUTER;
                else if (pattern_i == PAT_BOTH)  state_d = ST_IN_BOTH;
                else                             state_d = ST_IDLE;
            end
            ST_IN_BOTH: begin
                if (pattern_i == PAT_BOTH)       state_d = ST_IN_BOTH;
                else if (pattern_i == PAT_OUTER) state_d = ST_IN_OUTER;
                else if (pattern_i == PAT_INNER) state_d = ST_IN_INNER;
                else                             state_d = ST_IDLE;
            end
            ST_IN_INNER: begin
                if (pattern_i == PAT_INNER)      state_d = ST_IN_INNER;
                else if (pattern_i == PAT_BOTH)  state_d = ST_IN_BOTH;
                else begin
                    state_d    = ST_IDLE;
                    entry_done = (pattern_i == PAT_CLEAR);
                end
            end
            ST_OUT_INNER: begin
                if (pattern_i == PAT_INNER)      state_d = ST_OUT_INNER;
                else if (pattern_i == PAT_BOTH)  state_d = ST_OUT_BOTH;
                else                             state_d = ST_IDLE;
            end
            ST_OUT_BOTH: begin
                if (pattern_i == PAT_BOTH)       state_d = ST_OUT_BOTH;
                else if (pattern_i == PAT_INNER) state_d = ST_OUT_INNER;
                else if (pattern_i == PAT_OUTER) state_d = ST_OUT_OUTER;
                else                             state_d = ST_IDLE;
            end
            ST_OUT_OUTER: begin
                if (pattern_i == PAT_OUTER)      state_d = ST_OUT_OUTER;
                else if (pattern_i == PAT_BOTH)  state_d = ST_OUT_BOTH;
                else begin
                    state_d   = ST_IDLE;
                    exit_done = (pattern_i == PAT_CLEAR);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enter_o <= 1'b0;
            exit_o  <= 1'b0;
        end else begin
            enter_o <= entry_done && !full_i;
            exit_o  <= exit_done;
        end
    end

    p_enter_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        enter_o |=> !enter_o);
    p_exit_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        exit_o |=> !exit_o);
    p_enter_source_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(enter_o) |-> ($past(state_q) == ST_IN_INNER && $past(pattern_i) == PAT_CLEAR));
    p_exit_source_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(exit_o) |-> ($past(state_q) == ST_OUT_OUTER && $past(pattern_i) == PAT_CLEAR));
    p_back_up_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IN_BOTH && pattern_i == PAT_OUTER) |=> state_q == ST_IN_OUTER);
    p_abort_r5: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_IN_OUTER || state_q == ST_OUT_INNER) && pattern_i == PAT_CLEAR)
        |=> (state_q == ST_IDLE && !enter_o && !exit_o));
    p_idle_both_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && pattern_i == PAT_BOTH) |=> state_q == ST_IDLE);
endmodule

// File: rtl/gate_occupancy.sv
module gate_occupancy #(
    parameter int CAP = 64,
    localparam int CW = $clog2(CAP + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc_i,
    input  logic          dec_i,
    output logic [CW-1:0] count_o,
    output logic          full_o
);
    localparam logic [CW-1:0] CAP_V = CW'(CAP);

    always_ff @(posedge clk) begin
        if (rst)                               count_o <= '0;
        else if (inc_i && count_o != CAP_V)    count_o <= count_o + 1'b1;
        else if (dec_i && count_o != '0)       count_o <= count_o - 1'b1;
    end

    assign full_o = (count_o == CAP_V);

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        count_o <= CAP_V);
    p_inc_r7: assert property (@(posedge clk) disable iff (rst)
        (inc_i && !full_o) |=> count_o == $past(count_o) + 1'b1);
    p_dec_r7: assert property (@(posedge clk) disable iff (rst)
        (dec_i && !inc_i && count_o != '0) |=> count_o == $past(count_o) - 1'b1);
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (rst)
        (dec_i && !inc_i && count_o == '0) |=> count_o == '0);
endmodule

// File: rtl/gate_direction_ctrl.sv
module gate_direction_ctrl #(
    parameter int CAP = 64,
    localparam int CW = $clog2(CAP + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sb_i,
    input  logic          sf_i,
    output logic          enter_o,
    output logic          exit_o,
    output logic [CW-1:0] count_o,
    output logic          full_o
);
    logic [1:0] pattern;
    assign pattern = {sb_i, sf_i};

    gate_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .pattern_i (pattern),
        .full_i    (full_o),
        .enter_o   (enter_o),
        .exit_o    (exit_o)
    );

    gate_occupancy #(.CAP(CAP)) u_occ (
        .clk     (clk),
        .rst     (rst),
        .inc_i   (enter_o),
        .dec_i   (exit_o),
        .count_o (count_o),
        .full_o  (full_o)
    );

    p_full_blocks_entry_r8: assert property (@(posedge clk) disable iff (rst)
        full_o |-> !enter_o);
    p_one_direction_r2: assert property (@(posedge clk) disable iff (rst)
        !(enter_o && exit_o));
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!enter_o && !exit_o && count_o == '0));
endmodule

// File: tb/gate_direction_ctrl_tb.sv
module gate_direction_ctrl_tb;
    localparam int CAP = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sb  = 1'b0;
    logic       sf  = 1'b0;
    logic       enter_w, exit_w, full_w;
    logic [6:0] count_w;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    int  m_state = 0;
    int  m_count = 0;
    bit  pend_e  = 1'b0;
    bit  pend_x  = 1'b0;

    always #10 clk = ~clk;

    gate_direction_ctrl #(.CAP(CAP)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .sb_i    (sb),
        .sf_i    (sf),
        .enter_o (enter_w),
        .exit_o  (exit_w),
        .count_o (count_w),
        .full_o  (full_w)
    );

    task automatic chk(input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic int model_next(input int st, input int p, output bit din, output bit dout);
        din = 1'b0;
        dout = 1'b0;
        case (st)
            0: return (p == 2) ? 1 : (p == 1) ? 4 : 0;
            1: return (p == 2) ? 1 : (p == 3) ? 2 : 0;
            2: return (p == 3) ? 2 : (p == 2) ? 1 : (p == 1) ? 3 : 0;
            3: begin
                if (p == 1) return 3;
                if (p == 3) return 2;
                din = (p == 0);
                return 0;
            end
            4: return (p == 1) ? 4 : (p == 3) ? 5 : 0;
            5: return (p == 3) ? 5 : (p == 1) ? 4 : (p == 2) ? 6 : 0;
            6: begin
                if (p == 2) return 6;
                if (p == 3) return 5;
                dout = (p == 0);
                return 0;
            end
            default: return 0;
        endcase
    endfunction

    task automatic step(input int p, input string tag);
        bit din, dout, ee;
        int cnt_old;
        @(negedge clk);
        {sb, sf} = 2'(p);
        @(posedge clk);
        cnt_old = m_count;
        if (pend_e && m_count < CAP)   m_count++;
        else if (pend_x && m_count > 0) m_count--;
        m_state = model_next(m_state, p, din, dout);
        ee = din && (cnt_old != CAP);
        pend_e = ee;
        pend_x = dout;
        #5;
        chk(int'(enter_w), int'(ee),   {tag, " R2 enter_o"});
        chk(int'(exit_w),  int'(dout), {tag, " R3 exit_o"});
        chk(int'(count_w), m_count,    {tag, " R7 count_o"});
        chk(int'(full_w),  int'(m_count == CAP), {tag, " R8 full_o"});
    endtask

    task automatic pass_in(input string tag);
        step(2, tag); step(3, tag); step(1, tag); step(0, tag);
    endtask

    task automatic pass_out(input string tag);
        step(1, tag); step(3, tag); step(2, tag); step(0, tag);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240430));
        repeat (3) @(posedge clk);
        #5;
        chk(int'(enter_w), 0, "R1 enter_o in reset");
        chk(int'(count_w), 0, "R1 count_o in reset");
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #5;
        chk(int'(exit_w), 0, "R1 exit_o after reset");
        chk(int'(full_w), 0, "R1 full_o after reset");

        step(0, "R2");
        pass_in("R2");
        step(0, "R2");
        chk(int'(count_w), 1, "R7 count after one entry");
        pass_out("R3");
        step(0, "R3");
        chk(int'(count_w), 0, "R7 count after one exit");

        pass_out("R9");
        step(0, "R9");
        chk(int'(count_w), 0, "R9 count stays zero");

        step(2, "R5"); step(2, "R5"); step(0, "R5");
        step(1, "R5"); step(0, "R5");
        chk(int'(count_w), 0, "R5 abort leaves count");

        step(3, "R6"); step(1, "R6"); step(0, "R6");
        step(2, "R6"); step(3, "R6"); step(0, "R6");
        step(2, "R6"); step(1, "R6"); step(0, "R6");
        chk(int'(count_w), 0, "R6 rejects leave count");

        step(2, "R4"); step(3, "R4"); step(2, "R4"); step(2, "R4");
        step(3, "R4"); step(1, "R4"); step(3, "R4"); step(1, "R4");
        step(0, "R4"); step(0, "R4");
        chk(int'(count_w), 1, "R4 backed-up entry counted once");
        step(1, "R4"); step(3, "R4"); step(2, "R4"); step(3, "R4");
        step(1, "R4"); step(3, "R4"); step(2, "R4"); step(0, "R4");
        step(0, "R4");
        chk(int'(count_w), 0, "R4 backed-up exit counted once");

        for (int i = 0; i < CAP; i++) pass_in("R8 fill");
        step(0, "R8");
        chk(int'(full_w), 1, "R8 full at capacity");
        pass_in("R8 refused");
        step(0, "R8");
        chk(int'(count_w), CAP, "R8 count held at capacity");
        pass_out("R8");
        step(0, "R8");
        chk(int'(full_w), 0, "R8 full clears after exit");

        for (int i = 0; i < 300; i++) begin
            bit dir_in;
            int seq[4];
            dir_in = ($urandom % 2) == 0;
            seq = dir_in ? '{2, 3, 1, 0} : '{1, 3, 2, 0};
            for (int k = 0; k < 4; k++) begin
                if (($urandom % 8) == 0) step(int'($urandom % 4), "rand");
                else                     step(seq[k], "rand");
            end
        end
        step(0, "rand");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule